// File: doc/BRIEF.md
# Stream Broadcaster with Per-Output Buffering

This block copies every beat of one AXI4-Stream video input (data, user sideband and end-of-packet flag) onto N output streams. All ports share one clock. Each output that honours backpressure has its own small synchronous queue. The queue is either a ring buffer of parameterised depth or, at depth one, a single-entry holding register. A slow consumer therefore fills only its own queue and does not hold up the other outputs.

A build-time policy sets what happens when a queue is full. Under the stall policy, the input ready is withdrawn while any queue is full. Every queue then takes each beat in the same cycle, so each output sees the exact input sequence. Under the drop policy, the input is never held. A full output skips the beat, then keeps skipping up to and including the end of that packet, and resumes at the next packet start. Outputs built without a ready input get a plain register stage that forwards each accepted beat one cycle later. Such outputs never hold up the input.

Top module: `stream_bcast`

## Requirements
- R1: Under the stall policy, every output emits exactly the sequence of accepted input beats, with data, user and end-of-packet flag unchanged and in order.
- R2: A buffered output raises its valid whenever its queue holds a beat. While its ready is low, it holds the same beat and valid stays high.
- R3: Under the stall policy, the input ready is low exactly when at least one buffered output's queue is full. No queue is written in such a cycle.
- R4: Under the drop policy, the input ready stays high in every cycle after reset.
- R5: Under the drop policy, a buffered output whose queue is full when a beat is accepted discards that beat. The other outputs still receive it.
- R6: After a buffered output discards a beat, it discards every further beat up to and including the next beat with the end-of-packet flag set. It accepts again from the following beat onward.
- R7: An output built without ready ignores its out_ready input. It raises valid in the cycle after an input beat is accepted, carrying that beat, and lowers valid after any cycle with no accepted beat.
- R8: Outputs built without ready never cause the input ready to drop, even while their out_ready is low.
- R9: During and right after reset, all output valids are low and no queue holds data.
- R10: A depth-one queue holds a single beat. It reports full while occupied and accepts a new beat only after that beat has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all ports |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_data | input | DATA_W | Input pixel data |
| in_user | input | USER_W | Input sideband |
| in_last | input | 1 | Input end-of-packet flag |
| out_valid | output | N | Per-output valid |
| out_ready | input | N | Per-output ready, ignored on outputs built without it |
| out_data | output | N*DATA_W | Per-output data, output i in bits i*DATA_W upward |
| out_user | output | N*USER_W | Per-output sideband, output i in bits i*USER_W upward |
| out_last | output | N | Per-output end-of-packet flag |

## Verification
Some rules are checked on every cycle: a buffered output holds its beat steady while stalled, a full queue under the stall policy keeps the input ready low, the register-stage outputs forward exactly the accepted beats one cycle later, and valids are low right after reset. Other behaviour only shows over a long run. This covers the exact beat order per output, the discard decision taken against the queue level, the rule that discarding lasts to the end of the packet and not beyond it, and the absence of stalls caused by register-stage outputs. The bench shows these with a cycle-accurate reference model of each queue, driven by random and directed ready patterns.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    // Overflow handling selected at build time.
    typedef enum logic {
        POLICY_STALL = 1'b0,
        POLICY_DROP  = 1'b1
    } ovf_policy_e;

    // Pointer width for a ring of the given depth (never zero).
    function automatic int ptr_w(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Occupancy counter width able to hold 0..depth.
    function automatic int cnt_w(input int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/sbc_fifo.sv
module sbc_fifo
    import sbc_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    output logic         full,
    input  logic         pop,
    output logic         valid,
    output logic [W-1:0] rdata
);

    generate
        if (DEPTH == 1) begin : g_shim
            logic         v_q;
            logic [W-1:0] d_q;
            logic         wr;

            assign wr = push & ~v_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    v_q <= 1'b0;
                end else if (wr) begin
                    v_q <= 1'b1;
                end else if (pop) begin
                    v_q <= 1'b0;
                end
            end

            always_ff @(posedge clk) begin
                if (wr) d_q <= wdata;
            end

            assign full  = v_q;
            assign valid = v_q;
            assign rdata = d_q;
        end else begin : g_ring
            localparam int PW = ptr_w(DEPTH);
            localparam int CW = cnt_w(DEPTH);

            logic [W-1:0]  mem [DEPTH];
            logic [PW-1:0] wp_q, rp_q;
            logic [CW-1:0] cnt_q;
            logic          wr, rd;

            assign full  = (cnt_q == CW'(DEPTH));
            assign valid = (cnt_q != '0);
            assign wr    = push & ~full;
            assign rd    = pop & valid;
            assign rdata = mem[rp_q];

            always_ff @(posedge clk) begin
                if (rst) begin
                    wp_q  <= '0;
                    rp_q  <= '0;
                    cnt_q <= '0;
                end else begin
                    if (wr) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
                    if (rd) rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
                    cnt_q <= cnt_q + CW'(wr) - CW'(rd);
                end
            end

            always_ff @(posedge clk) begin
                if (wr) mem[wp_q] <= wdata;
            end
        end
    endgenerate

endmodule

// File: rtl/sbc_admit.sv
module sbc_admit (
    input  logic clk,
    input  logic rst,
    input  logic beat_fire,
    input  logic beat_last,
    input  logic buf_full,
    output logic push
);

    // Set while the rest of a partly discarded packet is being skipped.
    logic skip_q;
    logic discard;

    assign discard = beat_fire & (skip_q | buf_full);
    assign push    = beat_fire & ~skip_q & ~buf_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            skip_q <= 1'b0;
        end else if (beat_fire) begin
            skip_q <= discard & ~beat_last;
        end
    end

endmodule

// File: rtl/sbc_fwd_stage.sv
module sbc_fwd_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    output logic         valid,
    output logic [W-1:0] rdata
);

    logic         v_q;
    logic [W-1:0] d_q;

    always_ff @(posedge clk) begin
        if (rst) v_q <= 1'b0;
        else     v_q <= push;
    end

    always_ff @(posedge clk) begin
        if (push) d_q <= wdata;
    end

    assign valid = v_q;
    assign rdata = d_q;

endmodule

// File: rtl/stream_bcast.sv
module stream_bcast
    import sbc_pkg::*;
#(
    parameter int          N            = 3,
    parameter int          DATA_W       = 16,
    parameter int          USER_W       = 2,
    parameter int          DEPTH        = 4,
    parameter logic [N-1:0] OUT_READY_EN = '1,
    parameter bit          IN_READY_EN  = 1'b1,
    parameter ovf_policy_e POLICY       = POLICY_STALL
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [DATA_W-1:0]     in_data,
    input  logic [USER_W-1:0]     in_user,
    input  logic                  in_last,
    output logic [N-1:0]          out_valid,
    input  logic [N-1:0]          out_ready,
    output logic [N*DATA_W-1:0]   out_data,
    output logic [N*USER_W-1:0]   out_user,
    output logic [N-1:0]          out_last
);

    localparam int BW       = DATA_W + USER_W + 1;
    localparam bit STALL_ON = (POLICY == POLICY_STALL) && IN_READY_EN && (|OUT_READY_EN);

    logic [BW-1:0] in_beat;
    logic [N-1:0]  buf_full;
    logic          fire;

    assign in_beat  = {in_last, in_user, in_data};
    assign in_ready = STALL_ON ? ~(|buf_full) : 1'b1;
    assign fire     = in_valid & in_ready;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_out
            logic [BW-1:0] ob;
            logic          ov;

            if (OUT_READY_EN[i]) begin : g_buf
                logic push;
                logic full;

                sbc_admit u_admit (
                    .clk       (clk),
                    .rst       (rst),
                    .beat_fire (fire),
                    .beat_last (in_last),
                    .buf_full  (full),
                    .push      (push)
                );

                sbc_fifo #(.W(BW), .DEPTH(DEPTH)) u_fifo (
                    .clk   (clk),
                    .rst   (rst),
                    .push  (push),
                    .wdata (in_beat),
                    .full  (full),
                    .pop   (out_ready[i]),
                    .valid (ov),
                    .rdata (ob)
                );

                assign buf_full[i] = full;
            end else begin : g_fwd
                logic unused_rdy;
                assign unused_rdy = out_ready[i];

                sbc_fwd_stage #(.W(BW)) u_stage (
                    .clk   (clk),
                    .rst   (rst),
                    .push  (fire),
                    .wdata (in_beat),
                    .valid (ov),
                    .rdata (ob)
                );

                assign buf_full[i] = 1'b0;
            end

            assign out_valid[i]                  = ov;
            assign out_data[i*DATA_W +: DATA_W]  = ob[DATA_W-1:0];
            assign out_user[i*USER_W +: USER_W]  = ob[DATA_W +: USER_W];
            assign out_last[i]                   = ob[BW-1];
        end
    endgenerate

endmodule

// File: rtl/stream_bcast_checker.sv
module stream_bcast_checker #(
    parameter int           N            = 3,
    parameter int           DATA_W       = 16,
    parameter int           USER_W       = 2,
    parameter logic [N-1:0] OUT_READY_EN = '1,
    parameter bit           STALL_ON     = 1'b1
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_ready,
    input logic [DATA_W-1:0]   in_data,
    input logic [USER_W-1:0]   in_user,
    input logic                in_last,
    input logic [N-1:0]        out_valid,
    input logic [N-1:0]        out_ready,
    input logic [N*DATA_W-1:0] out_data,
    input logic [N*USER_W-1:0] out_user,
    input logic [N-1:0]        out_last,
    input logic [N-1:0]        buf_full
);

    p_reset_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_valid == '0));

    generate
        if (STALL_ON) begin : g_stall
            p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
                (|buf_full) |-> !in_ready);
        end

        for (genvar i = 0; i < N; i++) begin : g_chk
            if (OUT_READY_EN[i]) begin : g_buf
                p_hold_r2: assert property (@(posedge clk) disable iff (rst)
                    (out_valid[i] && !out_ready[i]) |=>
                        (out_valid[i] && $stable(out_data[i*DATA_W +: DATA_W])
                         && $stable(out_user[i*USER_W +: USER_W]) && $stable(out_last[i])));
            end else begin : g_fwd
                p_fwd_beat_r7: assert property (@(posedge clk) disable iff (rst)
                    (in_valid && in_ready) |=>
                        (out_valid[i] && out_data[i*DATA_W +: DATA_W] == $past(in_data)
                         && out_user[i*USER_W +: USER_W] == $past(in_user)
                         && out_last[i] == $past(in_last)));
                p_fwd_idle_r7: assert property (@(posedge clk) disable iff (rst)
                    !(in_valid && in_ready) |=> !out_valid[i]);
                p_no_stall_r8: assert property (@(posedge clk) disable iff (rst)
                    !buf_full[i]);
            end
        end
    endgenerate

endmodule

bind stream_bcast stream_bcast_checker #(
    .N            (N),
    .DATA_W       (DATA_W),
    .USER_W       (USER_W),
    .OUT_READY_EN (OUT_READY_EN),
    .STALL_ON     (STALL_ON)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_user   (in_user),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_user  (out_user),
    .out_last  (out_last),
    .buf_full  (buf_full)
);

// File: tb/stream_bcast_tb.sv
`timescale 1ns/1ps
module stream_bcast_tb;
    import sbc_pkg::*;

    localparam int NO = 3;
    localparam int DW = 16;
    localparam int UW = 2;
    localparam int BW = DW + UW + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    // Index 0: stall policy, depth 4, output 2 without ready.
    // Index 1: drop policy, depth 1, output 1 without ready.
    logic          sv [2];
    logic [DW-1:0] sd [2];
    logic [UW-1:0] su [2];
    logic          sl [2];
    logic [NO-1:0] ordy [2];
    logic          ir [2];
    logic [NO-1:0] ov [2];
    logic [NO*DW-1:0] od [2];
    logic [NO*UW-1:0] ou [2];
    logic [NO-1:0] ol [2];

    stream_bcast #(.N(NO), .DATA_W(DW), .USER_W(UW), .DEPTH(4),
                   .OUT_READY_EN(3'b011), .IN_READY_EN(1'b1), .POLICY(POLICY_STALL)) u_dut (
        .clk(clk), .rst(rst), .in_valid(sv[0]), .in_ready(ir[0]), .in_data(sd[0]),
        .in_user(su[0]), .in_last(sl[0]), .out_valid(ov[0]), .out_ready(ordy[0]),
        .out_data(od[0]), .out_user(ou[0]), .out_last(ol[0]));

    stream_bcast #(.N(NO), .DATA_W(DW), .USER_W(UW), .DEPTH(1),
                   .OUT_READY_EN(3'b101), .IN_READY_EN(1'b1), .POLICY(POLICY_DROP)) u_dut_drop (
        .clk(clk), .rst(rst), .in_valid(sv[1]), .in_ready(ir[1]), .in_data(sd[1]),
        .in_user(su[1]), .in_last(sl[1]), .out_valid(ov[1]), .out_ready(ordy[1]),
        .out_data(od[1]), .out_user(ou[1]), .out_last(ol[1]));

    int       cfg_depth [2] = '{4, 1};
    bit [2:0] cfg_en    [2] = '{3'b011, 3'b101};
    bit       cfg_stall [2] = '{1'b1, 1'b0};

    logic [BW-1:0] mq [2][NO][4];
    int            mh [2][NO];
    int            mc [2][NO];
    bit            mskip [2][NO];
    bit            rv [2][NO];
    logic [BW-1:0] rd [2][NO];
    int            drops [2][NO];
    int            seqn [2];
    bit            prev_fire [2];

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [BW-1:0] beat_at(input int d, input int o);
        return {ol[d][o], ou[d][o*UW +: UW], od[d][o*DW +: DW]};
    endfunction

    // rmode: 0 random ready, 1 all ready, 2 output 0 stalled, 3 nothing ready
    task automatic step(input int rmode);
        for (int d = 0; d < 2; d++) begin
            if (!sv[d] || prev_fire[d]) begin
                sv[d] = ($urandom % 4) != 0;
                sd[d] = DW'(seqn[d]);
                seqn[d]++;
                su[d] = UW'($urandom);
                sl[d] = ($urandom % 3) == 0;
            end
            for (int o = 0; o < NO; o++) begin
                case (rmode)
                    0: ordy[d][o] = $urandom % 2;
                    1: ordy[d][o] = 1'b1;
                    2: ordy[d][o] = (o != 0);
                    default: ordy[d][o] = 1'b0;
                endcase
            end
        end
        #1;
        for (int d = 0; d < 2; d++) begin
            bit exp_rdy = 1'b1;
            bit fire;
            logic [BW-1:0] ib;
            if (cfg_stall[d])
                for (int o = 0; o < NO; o++)
                    if (cfg_en[d][o] && mc[d][o] == cfg_depth[d]) exp_rdy = 1'b0;
            chk(ir[d] == exp_rdy, d == 0 ? (exp_rdy ? "R8" : "R3") : "R4", 32'(ir[d]), 32'(exp_rdy));
            fire = sv[d] && exp_rdy;
            ib = {sl[d], su[d], sd[d]};
            for (int o = 0; o < NO; o++) begin
                if (cfg_en[d][o]) begin
                    bit ev = mc[d][o] > 0;
                    bit full = mc[d][o] == cfg_depth[d];
                    chk(ov[d][o] == ev, d == 1 ? "R10" : "R2", 32'(ov[d][o]), 32'(ev));
                    if (ev)
                        chk(beat_at(d, o) == mq[d][o][mh[d][o]], d == 1 ? "R6" : "R1",
                            32'(beat_at(d, o)), 32'(mq[d][o][mh[d][o]]));
                    if (fire) begin
                        if (mskip[d][o] || full) begin
                            drops[d][o]++;
                            mskip[d][o] = !sl[d];
                        end else begin
                            mq[d][o][(mh[d][o] + mc[d][o]) % cfg_depth[d]] = ib;
                            mc[d][o]++;
                            mskip[d][o] = 1'b0;
                        end
                    end
                    if (ev && ordy[d][o]) begin
                        mh[d][o] = (mh[d][o] + 1) % cfg_depth[d];
                        mc[d][o]--;
                    end
                end else begin
                    chk(ov[d][o] == rv[d][o], "R7", 32'(ov[d][o]), 32'(rv[d][o]));
                    if (rv[d][o])
                        chk(beat_at(d, o) == rd[d][o], "R7", 32'(beat_at(d, o)), 32'(rd[d][o]));
                    rv[d][o] = fire;
                    if (fire) rd[d][o] = ib;
                end
            end
            prev_fire[d] = fire;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #750000;
        if (!done) begin
            nerr++;
            $display("FAIL R1 watchdog expired: actual=hang expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int d = 0; d < 2; d++) begin
            sv[d] = 1'b0; sd[d] = '0; su[d] = '0; sl[d] = 1'b0; ordy[d] = '0;
            seqn[d] = 0; prev_fire[d] = 1'b0;
            for (int o = 0; o < NO; o++) begin
                mh[d][o] = 0; mc[d][o] = 0; mskip[d][o] = 1'b0;
                rv[d][o] = 1'b0; rd[d][o] = '0; drops[d][o] = 0;
            end
        end
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            chk(ov[d] == '0, "R9", 32'(ov[d]), 32'd0);
        end
        rst = 1'b0;
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            chk(ov[d] == '0, "R9", 32'(ov[d]), 32'd0);
            chk(ir[d] == 1'b1, "R9", 32'(ir[d]), 32'd1);
        end

        repeat (30)   step(2);   // fill output 0: stall on index 0, drops on index 1
        repeat (1500) step(0);
        repeat (25)   step(3);   // nothing ready: only register stages move
        repeat (1500) step(0);
        repeat (60)   step(1);   // drain

        chk(drops[1][0] > 0, "R5", 32'(drops[1][0]), 32'd1);
        chk(drops[0][0] == 0 && drops[0][1] == 0, "R3", 32'(drops[0][0] + drops[0][1]), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule